// File: doc/BRIEF.md
# Delayed Read Target Controller

This block is the target side of a simplified parallel bus for memory reads that a slow memory subsystem serves. The master starts a read with a one-cycle address phase on `frame_n`. The block claims the read and sends a memory request together with a processor probe request. It then returns the first data word on `trdy_n` when memory answers.

When latency enforcement is on, a counter limits how long the master may wait for its first data phase. If memory is still busy when the limit is reached, the block signals a retry, frees the bus, and keeps the read in its single-entry queue while the memory access carries on. A later attempt with the same address and command takes the stored word at once. When enforcement is off, or a separate inhibit input is set, the block never retries on timeout. It holds the bus instead until data arrives.

Top module: `pci_dly_rd_tgt`

## Requirements
- R1: While reset is active, and after it with no traffic, `devsel_n`, `trdy_n` and `stop_n` are 1 and `mem_req` and `probe_req` are 0.
- R2: Only the command codes 4'h6, 4'hC and 4'hE are reads. With an empty queue, a read is claimed (`devsel_n` low) in cycle 1, where the address phase is cycle 0. Any other command is never claimed and starts no memory request.
- R3: A claimed read with an empty queue raises `mem_req` and `probe_req` together for exactly one cycle, in cycle 1, with `mem_addr` equal to the address of the read.
- R4: If `mem_ack` is high in cycle j, with 1 <= j <= LAT_LIMIT-1, then `trdy_n` goes low in cycle j+1 with `rdata` equal to `mem_data`. It stays low until the first clock edge at which `irdy_n` is low.
- R5: With `dly_en`=1 and `retry_inh`=0, a read that gets no data by cycle LAT_LIMIT-1 sees `stop_n` low, `trdy_n` high and `devsel_n` low in cycle LAT_LIMIT, for exactly one cycle, and the bus is then released.
- R6: With `dly_en`=0 or `retry_inh`=1, a timed-out read is never retried. `devsel_n` stays low with `trdy_n` and `stop_n` high until `mem_ack`, and data follows as in R4.
- R7: After a timeout retry, the memory word is captured when it arrives. The next read with the same address and command gets `trdy_n` low in cycle 1 with that word, and no new memory request is made.
- R8: A matching read that arrives before the queued word has returned is retried in cycle 1 with no memory request.
- R9: While the queue entry is occupied, a read whose address or command differs is retried in cycle 1, starts no memory request, and leaves the entry and its data unchanged.
- R10: Once the queued word has been delivered, the entry is free, and the next read makes a fresh memory request.
- R11: The latency count restarts with every transaction, so each timed-out read retries exactly in cycle LAT_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low transaction start; the low cycle after a high one is the address phase |
| irdy_n | input | 1 | Active-low master ready for the data phase |
| ad_addr | input | ADDR_W | Address, sampled in the address phase |
| cbe_cmd | input | 4 | Command code, sampled in the address phase |
| dly_en | input | 1 | Enables latency limit and delayed-read operation together |
| retry_inh | input | 1 | Suppresses retry on latency expiry |
| mem_ack | input | 1 | Memory read data valid (one-cycle pulse) |
| mem_data | input | DATA_W | Memory read data |
| devsel_n | output | 1 | Active-low target claims the transaction |
| trdy_n | output | 1 | Active-low target data ready |
| stop_n | output | 1 | Active-low target retry |
| rdata | output | DATA_W | Read data returned to the master |
| mem_req | output | 1 | One-cycle memory read request |
| probe_req | output | 1 | One-cycle processor probe request |
| mem_addr | output | ADDR_W | Address of the memory request |

## Verification
All sixteen command codes are swept to separate claimed reads from ignored ones. Memory latency is swept over every value that completes inside the window. This pins the data cycle to the acknowledge cycle and shows that the retry never fires early. Latencies at and past the limit, in each mode setting, tell the retry path apart from bus holding. A follow-up series of matching, early, address-mismatched and command-mismatched attempts shows how the queue entry is kept, served and freed.

// File: rtl/pci_dly_rd_tgt.sv
module pci_dly_rd_tgt #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LAT_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [ADDR_W-1:0] ad_addr,
  input  logic [3:0]        cbe_cmd,
  input  logic              dly_en,
  input  logic              retry_inh,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_data,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_req,
  output logic              probe_req,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int CW = $clog2(LAT_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LAT_LIMIT - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DATA, S_RETRY} st_t;
  st_t st;

  logic              frame_q;
  logic [CW-1:0]     cnt;
  logic              q_vld, q_done;
  logic [ADDR_W-1:0] q_addr;
  logic [3:0]        q_cmd;
  logic [DATA_W-1:0] q_data;

  wire dt    = dly_en & ~retry_inh;
  wire start = (st == S_IDLE) & ~frame_n & frame_q;
  wire is_rd = (cbe_cmd == 4'h6) | (cbe_cmd == 4'hC) | (cbe_cmd == 4'hE);
  wire hit   = (q_addr == ad_addr) & (q_cmd == cbe_cmd);

  assign devsel_n = (st == S_IDLE);
  assign trdy_n   = (st != S_DATA);
  assign stop_n   = (st != S_RETRY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      frame_q   <= 1'b1;
      cnt       <= '0;
      q_vld     <= 1'b0;
      q_done    <= 1'b0;
      q_addr    <= '0;
      q_cmd     <= '0;
      q_data    <= '0;
      rdata     <= '0;
      mem_req   <= 1'b0;
      probe_req <= 1'b0;
      mem_addr  <= '0;
    end else begin
      frame_q   <= frame_n;
      mem_req   <= 1'b0;
      probe_req <= 1'b0;
      if (mem_ack && st != S_WAIT && q_vld && !q_done) begin
        q_done <= 1'b1;
        q_data <= mem_data;
      end
      case (st)
        S_IDLE:
          if (start && is_rd) begin
            if (q_vld) begin
              if (hit && q_done) begin
                st    <= S_DATA;
                rdata <= q_data;
              end else begin
                st <= S_RETRY;
              end
            end else begin
              st        <= S_WAIT;
              cnt       <= CW'(1);
              q_addr    <= ad_addr;
              q_cmd     <= cbe_cmd;
              mem_req   <= 1'b1;
              probe_req <= 1'b1;
              mem_addr  <= ad_addr;
            end
          end
        S_WAIT:
          if (mem_ack) begin
            st    <= S_DATA;
            rdata <= mem_data;
          end else if (dt && cnt == LAST) begin
            st     <= S_RETRY;
            q_vld  <= 1'b1;
            q_done <= 1'b0;
          end else if (cnt != LAST) begin
            cnt <= cnt + CW'(1);
          end
        S_DATA:
          if (!irdy_n) begin
            st     <= S_IDLE;
            q_vld  <= 1'b0;
            q_done <= 1'b0;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_devsel_with_trdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);
  p_stop_trdy_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!stop_n && !trdy_n));
  p_retry_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |=> (stop_n && devsel_n));
  p_lat_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && dt) |-> (cnt < CW'(LAT_LIMIT)));
  p_hold_no_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !dt) |=> stop_n);
  p_no_req_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld |=> !mem_req);
endmodule

// File: tb/pci_dly_rd_tgt_tb.sv
module pci_dly_rd_tgt_tb_top;
  localparam int CLK_PER = 10;
  localparam int LAT = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1;
  logic [31:0] ad_addr = '0;
  logic [3:0] cbe_cmd = '0;
  logic dly_en = 1'b1, retry_inh = 1'b0;
  logic mem_ack = 1'b0;
  logic [31:0] mem_data = '0;
  logic devsel_n, trdy_n, stop_n, mem_req, probe_req;
  logic [31:0] rdata, mem_addr;

  pci_dly_rd_tgt #(.ADDR_W(32), .DATA_W(32), .LAT_LIMIT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad_addr(ad_addr), .cbe_cmd(cbe_cmd), .dly_en(dly_en), .retry_inh(retry_inh),
    .mem_ack(mem_ack), .mem_data(mem_data), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .rdata(rdata), .mem_req(mem_req), .probe_req(probe_req),
    .mem_addr(mem_addr));

  always #(CLK_PER/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return a * 32'h9E37_79B1 + 32'h0000_0055;
  endfunction

  int mem_lat = 0, left = 0;
  bit pend = 0;
  logic [31:0] pend_addr = '0;
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (mem_req) begin pend = 1; left = mem_lat; pend_addr = mem_addr; end
    else if (pend) left--;
    if (pend && left == 0) begin
      mem_ack = 1'b1; mem_data = mdata(pend_addr); pend = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  int t_dev, t_trdy, t_stop, n_trdy, n_stop, n_req;
  bit probe_bad, addr_bad;
  logic [31:0] got;

  task automatic do_read(input logic [31:0] a, input logic [3:0] c, input bit slow);
    @(negedge clk);
    frame_n = 1'b0; ad_addr = a; cbe_cmd = c; irdy_n = 1'b1;
    t_dev = 0; t_trdy = 0; t_stop = 0; n_trdy = 0; n_stop = 0; n_req = 0;
    probe_bad = 0; addr_bad = 0; got = '0;
    for (int t = 1; t <= 200; t++) begin
      @(negedge clk);
      if (t == 1) begin frame_n = 1'b1; if (!slow) irdy_n = 1'b0; end
      if (!devsel_n && t_dev == 0) t_dev = t;
      if (mem_req) begin n_req++; if (mem_addr !== a) addr_bad = 1; end
      if (mem_req !== probe_req) probe_bad = 1;
      if (!trdy_n) begin
        if (t_trdy == 0) begin t_trdy = t; got = rdata; end
        n_trdy++;
        if (slow && n_trdy == 3) irdy_n = 1'b0;
      end
      if (!stop_n) begin if (t_stop == 0) t_stop = t; n_stop++; end
      if ((t_trdy != 0 && trdy_n) || (t_stop != 0 && stop_n) || (t_dev == 0 && t >= 4)) break;
    end
    irdy_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !mem_req && !probe_req, "R1", "reset outputs",
        {devsel_n, trdy_n, stop_n, mem_req, probe_req}, 5'b11100);
    rst_n = 1'b1;
    idle(3);
    chk(devsel_n && trdy_n && stop_n && !mem_req, "R1", "idle outputs",
        {devsel_n, trdy_n, stop_n, mem_req}, 4'b1110);

    mem_lat = 0;
    for (int c = 0; c < 16; c++) begin
      bit rd;
      rd = (c == 6) || (c == 12) || (c == 14);
      do_read(32'h100 + c * 4, 4'(c), 0);
      if (rd)
        chk(t_dev == 1 && t_trdy == 2 && n_req == 1, "R2", "read cmd claimed, trdy cycle",
            t_trdy, 2);
      else
        chk(t_dev == 0 && n_req == 0, "R2", "non-read ignored, mem requests", n_req, 0);
      idle(2);
    end

    for (int l = 0; l <= LAT - 2; l++) begin
      logic [31:0] a;
      a = 32'h2000 + l * 16;
      mem_lat = l;
      do_read(a, 4'h6, 0);
      chk(t_trdy == l + 2 && got == mdata(a) && t_stop == 0 && n_trdy == 1, "R4",
          "data cycle for latency", t_trdy, l + 2);
      chk(n_req == 1 && !probe_bad && !addr_bad && t_dev == 1, "R3",
          "request/probe pair", n_req, 1);
      idle(2);
    end

    mem_lat = 3;
    do_read(32'h3000, 4'hE, 1);
    chk(n_trdy == 3 && t_trdy == 5 && got == mdata(32'h3000), "R4",
        "trdy held until irdy", n_trdy, 3);
    idle(2);

    mem_lat = LAT - 1;
    do_read(32'h4000, 4'h6, 0);
    chk(t_stop == LAT && n_stop == 1 && t_trdy == 0 && t_dev == 1, "R5",
        "retry cycle at limit", t_stop, LAT);
    idle(10);
    do_read(32'h4000, 4'h6, 0);
    chk(t_trdy == 1 && got == mdata(32'h4000) && n_req == 0, "R7",
        "queued data delivered at once", t_trdy, 1);
    idle(2);
    mem_lat = 2;
    do_read(32'h4100, 4'h6, 0);
    chk(n_req == 1 && t_trdy == 4 && got == mdata(32'h4100), "R10",
        "fresh request after free", n_req, 1);
    idle(2);

    mem_lat = 100;
    do_read(32'h5000, 4'h6, 0);
    chk(t_stop == LAT && t_trdy == 0, "R11", "second timeout at limit", t_stop, LAT);
    do_read(32'h5000, 4'h6, 0);
    chk(t_stop == 1 && n_req == 0 && t_trdy == 0, "R8", "early match retried", t_stop, 1);
    do_read(32'h5004, 4'h6, 0);
    chk(t_stop == 1 && n_req == 0, "R9", "address mismatch retried", t_stop, 1);
    do_read(32'h5000, 4'hC, 0);
    chk(t_stop == 1 && n_req == 0, "R9", "command mismatch retried", t_stop, 1);
    idle(120);
    do_read(32'h5004, 4'h6, 0);
    chk(t_stop == 1 && n_req == 0, "R9", "mismatch with data held", t_stop, 1);
    do_read(32'h5000, 4'h6, 0);
    chk(t_trdy == 1 && got == mdata(32'h5000) && n_req == 0, "R9",
        "entry kept through mismatches", got, mdata(32'h5000));
    idle(2);

    dly_en = 1'b0; mem_lat = 50;
    do_read(32'h6000, 4'h6, 0);
    chk(t_trdy == 52 && t_stop == 0 && got == mdata(32'h6000), "R6",
        "hold when disabled", t_trdy, 52);
    idle(2);
    dly_en = 1'b1; retry_inh = 1'b1; mem_lat = 40;
    do_read(32'h6100, 4'hC, 0);
    chk(t_trdy == 42 && t_stop == 0 && got == mdata(32'h6100), "R6",
        "hold when retry inhibited", t_trdy, 42);
    idle(2);
    retry_inh = 1'b0;

    mem_lat = LAT + 5;
    do_read(32'h7000, 4'hE, 0);
    chk(t_stop == LAT, "R11", "third timeout at limit", t_stop, LAT);
    idle(20);
    do_read(32'h7000, 4'hE, 0);
    chk(t_trdy == 1 && got == mdata(32'h7000), "R7", "late word served", t_trdy, 1);
    idle(2);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule